// File: doc/BRIEF.md
# SGRAM Power-Up Initialization Sequencer

This block owns the command pins of a two-bank synchronous graphics DRAM between reset and the moment the memory can accept ordinary traffic. While reset is held, and for a long settling pause after it is released, it drives a steady no-operation command with clock enable high and the byte masks high, so the data pins stay in high impedance. The pause and every gap that follows come from nanosecond figures held as parameters. Each figure is divided by the clock period parameter and rounded up to whole cycles.

After the pause the sequencer closes both banks with one precharge-all command. It then performs two steps whose order a configuration input selects: loading the mode register with the supplied mode word, and a burst of auto-refresh commands. It waits the required recovery time after every command. When the last step and its wait are over, it raises a done flag and drops the byte masks. From then on it drives no-operation until the next reset. The order input is captured when the pause ends. The mode word is placed on the address bus in the cycle of the mode-load command.

Top module: `sgram_init_seq`

## Requirements
- R1: While reset is low and during the pause that follows, the command {cs_n, ras_n, cas_n, we_n} is 4'b0111 (NOP), cke_o and dqm_o are 1, and done_o is 0.
- R2: The first command other than NOP is a precharge-all (4'b0010) with address bit 10 set. It appears after exactly ceil(T_PAUSE_NS / CLK_NS) active clock edges following reset release.
- R3: Every wait equals its nanosecond figure divided by CLK_NS, rounded up, with a floor of 2 cycles. The whole sequence therefore lasts pause + tRP + tRSC + REF_NUM·tRC cycles.
- R4: The command after the precharge follows it by exactly the tRP cycle count, with NOP in between.
- R5: The mode-load command is 4'b0000 and drives mode_word_i on addr_o in the same cycle.
- R6: Whatever follows the mode-load command (a refresh, or done) comes exactly tRSC cycles later.
- R7: Exactly REF_NUM auto-refresh commands (4'b0001) are issued. Each is followed by exactly tRC cycles before the next event.
- R8: If mrs_first_i is 1, the mode load comes right after the precharge wait and the refreshes follow it. If it is 0, the refreshes come first. The input is sampled when the pause ends, and later changes have no effect.
- R9: done_o rises, and dqm_o falls, exactly when the final wait ends. After that, done_o stays 1, dqm_o stays 0 and the command stays NOP.
- R10: Pulling rst_n low at any point returns the outputs to the R1 state at once, and the whole sequence restarts from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_word_i | input | ADDR_W | Value loaded into the mode register |
| mrs_first_i | input | 1 | 1: mode load before refreshes; 0: refreshes first |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable to the memory, held high |
| dqm_o | output | 1 | Byte mask; high until initialization completes |
| addr_o | output | ADDR_W | Address bus (bit 10 for precharge-all, mode word for mode load) |
| done_o | output | 1 | Initialization complete |

## Verification
The bench compares the command seen in every cycle against a schedule it builds from rounded-up timing figures. This catches a design that truncates instead of rounding, because it would issue each command a cycle early, and an off-by-one wait counter, because it would shift every later command. It runs both step orders and flips the order input just after the pause. A design that samples the input live would run the wrong order, and one that latches it too early would ignore the setting. A reset in the middle of the refresh burst is followed by a full run. A leftover refresh count would then show up as a missing refresh, and a timer that was not reloaded would show up as a shortened pause. The bench also checks that done appears exactly once the final wait ends and that the byte masks stay high until then.

// File: rtl/sgram_init_pkg.sv
package sgram_init_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_WAIT_RP,
    ST_MRS,
    ST_WAIT_RSC,
    ST_REF,
    ST_WAIT_RC,
    ST_READY
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_MRS = 4'b0000
  } sdram_cmd_t;

  // Nanoseconds to whole clock cycles, rounding up.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // Gaps between commands are counted with a floor of two cycles.
  function automatic int unsigned gap_cycles(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = ns_to_cycles(ns, clk_ns);
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/sgram_wait_timer.sv
module sgram_wait_timer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RESET_VAL = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (dec_i & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(RESET_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  p_load_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_hold_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/sgram_ref_counter.sv
module sgram_ref_counter #(
  parameter int unsigned REF_NUM = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  output logic all_done_o
);

  localparam int unsigned RC_W = $clog2(REF_NUM + 1);

  logic [RC_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign all_done_o = (cnt_q == RC_W'(REF_NUM));
  assign cnt_en     = inc_i & ~all_done_o;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_ref_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    all_done_o |=> all_done_o);

  p_ref_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !all_done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/sgram_cmd_encode.sv
module sgram_cmd_encode
  import sgram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  seq_state_t        state_i,
  input  logic [ADDR_W-1:0] mode_word_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o,
  output logic              done_o
);

  localparam int unsigned ALL_BANKS_BIT = 10;

  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    dqm_o  = 1'b1;
    done_o = 1'b0;
    unique case (state_i)
      ST_PRE: begin
        cmd_o                 = CMD_PRE;
        addr_o[ALL_BANKS_BIT] = 1'b1;
      end
      ST_MRS: begin
        cmd_o  = CMD_MRS;
        addr_o = mode_word_i;
      end
      ST_REF:   cmd_o = CMD_REF;
      ST_READY: begin
        dqm_o  = 1'b0;
        done_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sgram_init_seq.sv
module sgram_init_seq
  import sgram_init_pkg::*;
#(
  parameter int unsigned CLK_NS     = 7,
  parameter int unsigned T_PAUSE_NS = 200000,
  parameter int unsigned T_RP_NS    = 15,
  parameter int unsigned T_RC_NS    = 45,
  parameter int unsigned T_RSC_NS   = 10,
  parameter int unsigned REF_NUM    = 8,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word_i,
  input  logic              mrs_first_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic              dqm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam int unsigned PAUSE_CYC = ns_to_cycles(T_PAUSE_NS, CLK_NS);
  localparam int unsigned RP_CYC    = gap_cycles(T_RP_NS, CLK_NS);
  localparam int unsigned RC_CYC    = gap_cycles(T_RC_NS, CLK_NS);
  localparam int unsigned RSC_CYC   = gap_cycles(T_RSC_NS, CLK_NS);
  localparam int unsigned MAX_GAP   = (RP_CYC > RC_CYC) ? ((RP_CYC > RSC_CYC) ? RP_CYC : RSC_CYC)
                                                        : ((RC_CYC > RSC_CYC) ? RC_CYC : RSC_CYC);
  localparam int unsigned MAX_CYC   = (PAUSE_CYC > MAX_GAP) ? PAUSE_CYC : MAX_GAP;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  seq_state_t       state_q, state_d;
  logic             order_q, order_d, order_en;
  logic             tmr_load, tmr_dec, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             ref_inc, refs_all;
  logic [3:0]       cmd_w;

  sgram_wait_timer #(
    .CNT_W     (CNT_W),
    .RESET_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .expired_o  (tmr_expired)
  );

  sgram_ref_counter #(
    .REF_NUM (REF_NUM)
  ) u_refs (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (ref_inc),
    .all_done_o (refs_all)
  );

  sgram_cmd_encode #(
    .ADDR_W (ADDR_W)
  ) u_enc (
    .state_i     (state_q),
    .mode_word_i (mode_word_i),
    .cmd_o       (cmd_w),
    .addr_o      (addr_o),
    .dqm_o       (dqm_o),
    .done_o      (done_o)
  );

  // Next-state and control.
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    ref_inc  = 1'b0;
    order_en = 1'b0;
    order_d  = mrs_first_i;
    unique case (state_q)
      ST_PAUSE: begin
        tmr_dec = 1'b1;
        if (tmr_expired) begin
          order_en = 1'b1;
          state_d  = ST_PRE;
        end
      end
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RP_CYC - 2);
        state_d  = ST_WAIT_RP;
      end
      ST_WAIT_RP: begin
        tmr_dec = 1'b1;
        if (tmr_expired) state_d = order_q ? ST_MRS : ST_REF;
      end
      ST_MRS: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RSC_CYC - 2);
        state_d  = ST_WAIT_RSC;
      end
      ST_WAIT_RSC: begin
        tmr_dec = 1'b1;
        if (tmr_expired) state_d = order_q ? ST_REF : ST_READY;
      end
      ST_REF: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RC_CYC - 2);
        ref_inc  = 1'b1;
        state_d  = ST_WAIT_RC;
      end
      ST_WAIT_RC: begin
        tmr_dec = 1'b1;
        if (tmr_expired) begin
          if (!refs_all)    state_d = ST_REF;
          else if (order_q) state_d = ST_READY;
          else              state_d = ST_MRS;
        end
      end
      ST_READY: state_d = ST_READY;
      default:  state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PAUSE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        order_q <= 1'b1;
    else if (order_en) order_q <= order_d;
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_w;
  assign cke_o = 1'b1;

  p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAUSE) |-> (cmd_w == CMD_NOP && dqm_o && !done_o));

  p_pre_all_banks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == CMD_PRE) |-> addr_o[10]);

  p_pre_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == CMD_PRE) |=> (cmd_w == CMD_NOP));

  p_mrs_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == CMD_MRS) |-> (addr_o == mode_word_i));

  p_mrs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == CMD_MRS) |=> (cmd_w == CMD_NOP && !done_o));

  p_ref_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == CMD_REF) |=> (cmd_w == CMD_NOP && !done_o));

  p_done_needs_refs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> refs_all);

  p_order_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_PAUSE) |=> $stable(order_q));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && !dqm_o && cmd_w == CMD_NOP));

  p_one_hot_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_w == CMD_PRE, cmd_w == CMD_MRS, cmd_w == CMD_REF, done_o}));

endmodule

// File: tb/sgram_init_seq_tb.sv
`timescale 1ns/1ps
module sgram_init_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_NS     = 7;
  localparam int PAUSE_NS   = 2000;
  localparam int REFN       = 8;
  localparam int AW         = 12;

  // Independent rounding: ceil(ns / clk), floor of 2 for gaps.
  localparam int P   = (PAUSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP  = ((15 + CLK_NS - 1) / CLK_NS < 2) ? 2 : (15 + CLK_NS - 1) / CLK_NS;
  localparam int RC  = ((45 + CLK_NS - 1) / CLK_NS < 2) ? 2 : (45 + CLK_NS - 1) / CLK_NS;
  localparam int RSC = ((10 + CLK_NS - 1) / CLK_NS < 2) ? 2 : (10 + CLK_NS - 1) / CLK_NS;
  localparam int DONE_OFF = RP + RSC + REFN * RC;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  // {mrs_first, mode word, expected mode-load offset after the precharge}
  localparam logic [20:0] VECS [0:3] = '{
    {1'b1, 12'h033, 8'd3},
    {1'b0, 12'h027, 8'd59},
    {1'b1, 12'h000, 8'd3},
    {1'b0, 12'hFFF, 8'd59}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] mode_word;
  logic          mrs_first;
  logic          cs_n, ras_n, cas_n, we_n, cke, dqm, done;
  logic [AW-1:0] addr;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sgram_init_seq #(
    .CLK_NS     (CLK_NS),
    .T_PAUSE_NS (PAUSE_NS),
    .REF_NUM    (REFN),
    .ADDR_W     (AW)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_word_i (mode_word),
    .mrs_first_i (mrs_first),
    .cs_n_o      (cs_n),
    .ras_n_o     (ras_n),
    .cas_n_o     (cas_n),
    .we_n_o      (we_n),
    .cke_o       (cke),
    .dqm_o       (dqm),
    .addr_o      (addr),
    .done_o      (done)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input int k, input int mrs_off, input bit mf);
    int ref_base;
    ref_base = mf ? P + RP + RSC : P + RP;
    if (k == P) return C_PRE;
    if (k == P + mrs_off) return C_MRS;
    if (k >= ref_base && (k - ref_base) % RC == 0 && (k - ref_base) / RC < REFN) return C_REF;
    return C_NOP;
  endfunction

  task automatic run_seq(input bit mf, input logic [AW-1:0] mw, input int mrs_off,
                         input int flip_at, input int abort_at, input string tag);
    bit  pause_ok, after_ok, dqm_ok;
    int  mism, first_bad, pre_k, refs, done_k;
    logic [AW-1:0] mrs_addr;
    logic          pre_a10;
    logic [3:0]    c;
    pause_ok = 1; after_ok = 1; dqm_ok = 1;
    mism = 0; first_bad = -1; pre_k = -1; refs = 0; done_k = -1;
    mrs_addr = '0; pre_a10 = 1'b0;

    @(negedge clk);
    rst_n = 1'b0; mrs_first = mf; mode_word = mw;
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP && cke && dqm && !done,
        {tag, " R1 R10 outputs idle in reset"}, int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
    rst_n = 1'b1;

    for (int k = 1; k <= P + DONE_OFF + 20; k++) begin
      @(negedge clk);
      c = {cs_n, ras_n, cas_n, we_n};
      if (k < P && !(c == C_NOP && cke && dqm && !done)) pause_ok = 0;
      if (c != exp_cmd(k, mrs_off, mf)) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
      if (c == C_PRE && pre_k < 0) begin pre_k = k; pre_a10 = addr[10]; end
      if (c == C_MRS) mrs_addr = addr;
      if (c == C_REF) refs++;
      if (done && done_k < 0) done_k = k;
      if (done_k < 0 && !dqm) dqm_ok = 0;
      if (done_k >= 0 && !(done && !dqm && c == C_NOP)) after_ok = 0;
      if (k == flip_at) mrs_first = ~mf;
      if (k == abort_at) return;
    end

    chk(pause_ok, {tag, " R1 NOP/cke/dqm during pause"}, int'(pause_ok), 1);
    chk(pre_k == P, {tag, " R2 precharge cycle"}, pre_k, P);
    chk(pre_a10 == 1'b1, {tag, " R2 precharge-all A10"}, int'(pre_a10), 1);
    chk(mism == 0, {tag, " R4 R6 R7 R8 schedule, first bad cycle"}, first_bad, -1);
    chk(mrs_addr == mw, {tag, " R5 mode word on address"}, int'(mrs_addr), int'(mw));
    chk(refs == REFN, {tag, " R7 refresh count"}, refs, REFN);
    chk(done_k == P + DONE_OFF, {tag, " R3 R9 done cycle"}, done_k, P + DONE_OFF);
    chk(dqm_ok && after_ok, {tag, " R9 dqm high until done, then quiet"}, int'(dqm_ok && after_ok), 1);
  endtask

  initial begin : watchdog
    wait (cyc > 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; mrs_first = 1'b1; mode_word = '0;

    // Table of stimulus and expected offsets (R2 R3 R5 R7 R8 R9).
    for (int i = 0; i < 4; i++) begin
      run_seq(VECS[i][20], VECS[i][19:8], int'(VECS[i][7:0]), -1, -1, $sformatf("vec%0d", i));
    end

    // R8: order input flipped right after the pause ends must be ignored.
    run_seq(1'b1, 12'h0A5, RP, P + 1, -1, "R8 flip-after-pause mf1");
    run_seq(1'b0, 12'h15A, RP + REFN * RC, P + 1, -1, "R8 flip-after-pause mf0");

    // R10: reset in the middle of the refresh burst, then a full clean run.
    run_seq(1'b0, 12'h3C3, RP + REFN * RC, -1, P + RP + 3 * RC + 1, "R10 abort");
    run_seq(1'b0, 12'h3C3, RP + REFN * RC, -1, -1, "R10 restart");

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule